// File: doc/BRIEF.md
# Double-Buffered UART Transmitter

This block serialises characters onto an asynchronous line. Software-side logic writes a character into a one-entry holding buffer. The buffer is handed to a separate shift register as soon as that register is free, so the next character can be written while the current one is still on the wire. Characters carry five to nine data bits. Each frame can add an even or odd parity bit and ends with one or two stop bits. A free-running divider produces baud ticks. A bit lasts sixteen ticks, or eight when the double-speed input is set.

Two flags report progress. The buffer-empty flag says a new character may be written. The done flag says the line has gone quiet with nothing left queued. Each flag feeds its own interrupt output, gated by a per-flag enable and a global enable. The transmitter enable takes over the pin. When the enable drops, the block keeps driving the pin until every queued character has left. Only then does it let go of the pin.

Top module: `uart_dbuf_tx`

## Requirements
- R1: After reset, bufEmpty is 1, txDone is 0, txDrive is 0, txPin is 1, and both interrupt outputs are 0.
- R2: A frame is a low start bit, then the data bits least significant first, then high stop bits, and the line idles high. charSel values 0 to 3 give 5 to 8 data bits; values 4 to 7 give 9 data bits.
- R3: When parityEn is 1, one parity bit follows the last data bit. It makes the count of ones across the data bits and the parity bit even when parityOdd is 0, and odd when parityOdd is 1.
- R4: twoStop 0 gives one stop bit and twoStop 1 gives two.
- R5: One bit lasts 16*(baudDiv+1) clock cycles, or 8*(baudDiv+1) when dblSpeed is 1.
- R6: In 9-bit frames the ninth data bit is the value of wrBit8 captured with the character write. Its stored value resets to 0.
- R7: A write clears bufEmpty. On the first baud tick at which the shift register is idle and the transmitter is enabled, the buffer moves into the shift register, the start bit begins, and bufEmpty sets in that same cycle.
- R8: A write while bufEmpty is 0 is ignored: neither the queued character nor the transmitted frames change.
- R9: txDone sets when the last stop bit ends while the buffer is empty. It stays set until the next accepted write clears it.
- R10: emptyIrq is 1 only when emptyIrqEn, globalIrqEn and bufEmpty are all 1. doneIrq is 1 only when doneIrqEn, globalIrqEn and txDone are all 1.
- R11: While txEnable is 1, txDrive is 1. After txEnable drops, txDrive stays 1 until both the shift register and the buffer are empty, then goes to 0. While txDrive is 0, txPin is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txEnable | input | 1 | Transmitter enable request |
| dblSpeed | input | 1 | Shortens a bit to 8 baud ticks |
| baudDiv | input | DIV_W | Baud tick every baudDiv+1 clocks |
| charSel | input | 3 | Data length code (0..3 = 5..8 bits, 4..7 = 9 bits) |
| parityEn | input | 1 | Append a parity bit |
| parityOdd | input | 1 | Odd parity when 1, even when 0 |
| twoStop | input | 1 | Two stop bits when 1 |
| wrEn | input | 1 | Character write strobe |
| wrData | input | 8 | Low eight data bits of the character |
| wrBit8 | input | 1 | Ninth data bit of the character |
| emptyIrqEn | input | 1 | Buffer-empty interrupt enable |
| doneIrqEn | input | 1 | Done interrupt enable |
| globalIrqEn | input | 1 | Global interrupt enable |
| txPin | output | 1 | Serial line |
| txDrive | output | 1 | Transmitter owns the pin |
| bufEmpty | output | 1 | Holding buffer can accept a write |
| txDone | output | 1 | Last frame finished with nothing queued |
| emptyIrq | output | 1 | Gated buffer-empty interrupt |
| doneIrq | output | 1 | Gated done interrupt |

## Verification
The frame path is tested with several formats. A plain 8-bit frame fixes the bit order. A 5-bit frame with two stop bits and even parity separates length decoding from stop handling. A 7-bit frame with odd parity shows that the parity sense follows its control. Two 9-bit frames with opposite ninth bits show where that bit comes from. A double-speed run, decoded at half the bit period, would misread the data if the divisor ignored that control. Back-to-back writes, including a third write made while the buffer is full, separate correct handoff from overwriting. A write followed by an immediate enable drop shows whether the release is deferred or abrupt.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  // longest frame: start + 9 data + parity + 2 stop
  localparam int FRAME_W = 13;

  typedef struct packed {
    logic wrBuf;   // capture the write into the holding buffer
    logic load;    // move buffer into the shift register
    logic shift;   // advance the shift register by one bit
  } txStrobe_t;

  function automatic logic [3:0] dataBits(input logic [2:0] sel);
    return sel[2] ? 4'd9 : 4'd5 + {2'b00, sel[1:0]};
  endfunction

  function automatic logic [3:0] frameBits(input logic [2:0] sel,
                                           input logic parEn,
                                           input logic twoStop);
    return 4'd2 + dataBits(sel) + {3'b000, parEn} + {3'b000, twoStop};
  endfunction

endpackage

// File: rtl/uart_tx_datapath.sv
module uart_tx_datapath
  import uart_tx_pkg::*;
#(
  parameter int FRAME_LEN = FRAME_W
) (
  input  logic       clk,
  input  logic       rstN,
  input  txStrobe_t  strobe,
  input  logic [7:0] wrData,
  input  logic       wrBit8,
  input  logic [2:0] charSel,
  input  logic       parityEn,
  input  logic       parityOdd,
  output logic       txBit
);

  logic [8:0]           holdBuf;
  logic [FRAME_LEN-1:0] shReg;
  logic [FRAME_LEN-1:0] frameNext;
  logic [3:0]           nData;
  logic                 parBit;

  assign nData = dataBits(charSel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdBuf <= '0;
    end else if (strobe.wrBuf) begin
      holdBuf <= {wrBit8, wrData};
    end
  end

  // Assemble the frame: unused high positions stay 1 and act as stop bits.
  always_comb begin
    frameNext    = '1;
    frameNext[0] = 1'b0;
    parBit       = parityOdd;
    for (int i = 0; i < 9; i++) begin
      if (4'(i) < nData) begin
        frameNext[i+1] = holdBuf[i];
        parBit         = parBit ^ holdBuf[i];
      end
    end
    for (int i = 1; i < FRAME_LEN; i++) begin
      if (parityEn && (4'(i) == nData + 4'd1)) begin
        frameNext[i] = parBit;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '1;
    end else if (strobe.load) begin
      shReg <= frameNext;
    end else if (strobe.shift) begin
      shReg <= {1'b1, shReg[FRAME_LEN-1:1]};
    end
  end

  assign txBit = shReg[0];

endmodule

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
  import uart_tx_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txEnable,
  input  logic             dblSpeed,
  input  logic [DIV_W-1:0] baudDiv,
  input  logic [2:0]       charSel,
  input  logic             parityEn,
  input  logic             twoStop,
  input  logic             wrEn,
  input  logic             emptyIrqEn,
  input  logic             doneIrqEn,
  input  logic             globalIrqEn,
  output txStrobe_t        strobe,
  output logic             bufEmpty,
  output logic             txDone,
  output logic             txDrive,
  output logic             emptyIrq,
  output logic             doneIrq
);

  localparam int PHASE_W = 4;

  logic [DIV_W-1:0]   divCnt;
  logic               tick;
  logic [PHASE_W-1:0] phase;
  logic [PHASE_W-1:0] lastPhase;
  logic [3:0]         bitsLeft;
  logic               busy;
  logic               effEn;
  logic               bitDone;

  // baud tick generator
  assign tick = (divCnt == '0);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     divCnt <= '0;
    else if (tick) divCnt <= baudDiv;
    else           divCnt <= divCnt - 1'b1;
  end

  assign lastPhase = dblSpeed ? PHASE_W'(7) : PHASE_W'(15);
  assign bitDone   = busy && tick && (phase >= lastPhase);

  assign strobe.wrBuf = wrEn && bufEmpty;
  assign strobe.load  = tick && !busy && !bufEmpty && effEn;
  assign strobe.shift = bitDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      phase    <= '0;
      bitsLeft <= '0;
    end else if (strobe.load) begin
      busy     <= 1'b1;
      phase    <= '0;
      bitsLeft <= frameBits(charSel, parityEn, twoStop);
    end else if (bitDone) begin
      phase    <= '0;
      bitsLeft <= bitsLeft - 4'd1;
      if (bitsLeft == 4'd1) busy <= 1'b0;
    end else if (busy && tick) begin
      phase <= phase + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufEmpty <= 1'b1;
      txDone   <= 1'b0;
      effEn    <= 1'b0;
    end else begin
      if (strobe.wrBuf)     bufEmpty <= 1'b0;
      else if (strobe.load) bufEmpty <= 1'b1;

      if (strobe.wrBuf)                                  txDone <= 1'b0;
      else if (bitDone && bitsLeft == 4'd1 && bufEmpty)  txDone <= 1'b1;

      if (txEnable)              effEn <= 1'b1;
      else if (!busy && bufEmpty) effEn <= 1'b0;
    end
  end

  assign txDrive  = effEn;
  assign emptyIrq = emptyIrqEn && globalIrqEn && bufEmpty;
  assign doneIrq  = doneIrqEn && globalIrqEn && txDone;

endmodule

// File: rtl/uart_dbuf_tx.sv
module uart_dbuf_tx
  import uart_tx_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txEnable,
  input  logic             dblSpeed,
  input  logic [DIV_W-1:0] baudDiv,
  input  logic [2:0]       charSel,
  input  logic             parityEn,
  input  logic             parityOdd,
  input  logic             twoStop,
  input  logic             wrEn,
  input  logic [7:0]       wrData,
  input  logic             wrBit8,
  input  logic             emptyIrqEn,
  input  logic             doneIrqEn,
  input  logic             globalIrqEn,
  output logic             txPin,
  output logic             txDrive,
  output logic             bufEmpty,
  output logic             txDone,
  output logic             emptyIrq,
  output logic             doneIrq
);

  txStrobe_t strobe;
  logic      txBit;

  uart_tx_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .dblSpeed(dblSpeed),
    .baudDiv(baudDiv), .charSel(charSel), .parityEn(parityEn),
    .twoStop(twoStop), .wrEn(wrEn), .emptyIrqEn(emptyIrqEn),
    .doneIrqEn(doneIrqEn), .globalIrqEn(globalIrqEn), .strobe(strobe),
    .bufEmpty(bufEmpty), .txDone(txDone), .txDrive(txDrive),
    .emptyIrq(emptyIrq), .doneIrq(doneIrq)
  );

  uart_tx_datapath #(.FRAME_LEN(FRAME_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .wrBit8(wrBit8), .charSel(charSel), .parityEn(parityEn),
    .parityOdd(parityOdd), .txBit(txBit)
  );

  // released pin reads as idle high
  assign txPin = txDrive ? txBit : 1'b1;

endmodule

// File: rtl/uart_dbuf_tx_chk.sv
module uart_dbuf_tx_chk (
  input logic clk,
  input logic rstN,
  input logic txEnable,
  input logic txPin,
  input logic txDrive,
  input logic bufEmpty,
  input logic txDone,
  input logic emptyIrq,
  input logic doneIrq,
  input logic emptyIrqEn,
  input logic doneIrqEn,
  input logic globalIrqEn
);

  // R9
  done_needs_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    txDone |-> bufEmpty);

  // R10
  empty_irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    emptyIrq |-> (bufEmpty && emptyIrqEn && globalIrqEn));

  // R10
  done_irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |-> (txDone && doneIrqEn && globalIrqEn));

  // R11
  released_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !txDrive |-> txPin);

  // R11
  deferred_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txDrive) |-> (!$past(txEnable) && $past(bufEmpty)));

  // R7
  handoff_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bufEmpty) |-> (txDrive && !txPin));

endmodule

bind uart_dbuf_tx uart_dbuf_tx_chk u_chk (
  .clk(clk), .rstN(rstN), .txEnable(txEnable), .txPin(txPin),
  .txDrive(txDrive), .bufEmpty(bufEmpty), .txDone(txDone),
  .emptyIrq(emptyIrq), .doneIrq(doneIrq), .emptyIrqEn(emptyIrqEn),
  .doneIrqEn(doneIrqEn), .globalIrqEn(globalIrqEn)
);

// File: tb/uart_dbuf_tx_tb.sv
module uart_dbuf_tx_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DIV_W      = 16;
  localparam int WATCHDOG   = 150000;

  typedef struct {
    logic [8:0] data;
    int         nBits;
    bit         par;
    bit         odd;
    bit         two;
    int         period;
  } expItem_t;

  logic clk = 0;
  logic rstN = 0;
  logic txEnable = 0, dblSpeed = 0, parityEn = 0, parityOdd = 0, twoStop = 0;
  logic [DIV_W-1:0] baudDiv = 16'd1;
  logic [2:0] charSel = 3'd3;
  logic wrEn = 0, wrBit8 = 0;
  logic [7:0] wrData = '0;
  logic emptyIrqEn = 0, doneIrqEn = 0, globalIrqEn = 0;
  logic txPin, txDrive, bufEmpty, txDone, emptyIrq, doneIrq;

  int checks = 0;
  int failures = 0;
  expItem_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_dbuf_tx #(.DIV_W(DIV_W)) u_dut (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .dblSpeed(dblSpeed),
    .baudDiv(baudDiv), .charSel(charSel), .parityEn(parityEn),
    .parityOdd(parityOdd), .twoStop(twoStop), .wrEn(wrEn), .wrData(wrData),
    .wrBit8(wrBit8), .emptyIrqEn(emptyIrqEn), .doneIrqEn(doneIrqEn),
    .globalIrqEn(globalIrqEn), .txPin(txPin), .txDrive(txDrive),
    .bufEmpty(bufEmpty), .txDone(txDone), .emptyIrq(emptyIrq),
    .doneIrq(doneIrq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int bitPeriod();
    return (int'(baudDiv) + 1) * (dblSpeed ? 8 : 16);
  endfunction

  // driver: wait for room, write, push expected frame
  task automatic sendChar(input logic [8:0] d);
    expItem_t it;
    while (!bufEmpty) @(negedge clk);
    it.data   = d;
    it.nBits  = charSel[2] ? 9 : 5 + int'(charSel[1:0]);
    it.par    = parityEn;
    it.odd    = parityOdd;
    it.two    = twoStop;
    it.period = bitPeriod();
    expQ.push_back(it);
    wrData = d[7:0];
    wrBit8 = d[8];
    wrEn   = 1'b1;
    @(negedge clk);
    wrEn   = 1'b0;
  endtask

  task automatic waitDone();
    while (!txDone) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // monitor: decode each frame at mid-bit and compare with the queue
  initial begin
    expItem_t it;
    int       p;
    logic [8:0] got;
    logic     par, gotPar, stopOk, startOk;
    forever begin
      @(negedge clk);
      if (txDrive && !txPin) begin
        if (expQ.size() == 0) begin
          check(0, "R8 unexpected frame", 1, 0);
          p = bitPeriod();
          it.nBits = 8; it.par = 0; it.two = 0; it.odd = 0; it.data = '0;
        end else begin
          it = expQ.pop_front();
          p  = it.period;
        end
        repeat (p/2 - 1) @(negedge clk);
        startOk = (txPin == 1'b0);
        got = '0;
        par = it.odd;
        for (int i = 0; i < it.nBits; i++) begin
          repeat (p) @(negedge clk);
          got[i] = txPin;
          par    = par ^ txPin;
        end
        gotPar = par;
        if (it.par) begin
          repeat (p) @(negedge clk);
          gotPar = txPin;
        end
        stopOk = 1'b1;
        for (int s = 0; s < (it.two ? 2 : 1); s++) begin
          repeat (p) @(negedge clk);
          if (txPin !== 1'b1) stopOk = 1'b0;
        end
        // R2 R5 R6 data bits, order, bit period, ninth bit
        check(startOk && got == (it.data & ((9'h1 << it.nBits) - 1)),
              "R2/R5/R6 frame data", int'(got), int'(it.data & ((9'h1 << it.nBits) - 1)));
        // R3 parity bit
        if (it.par) check(gotPar == par, "R3 parity", int'(gotPar), int'(par));
        // R4 stop bits
        check(stopOk, "R4 stop bits", int'(stopOk), 1);
      end
    end
  end

  // watchdog
  initial begin
    repeat (WATCHDOG) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(bufEmpty == 1 && txDone == 0, "R1 flags", int'({bufEmpty, txDone}), 2);
    check(txDrive == 0 && txPin == 1, "R1 pin", int'({txDrive, txPin}), 1);
    check(emptyIrq == 0 && doneIrq == 0, "R1 irq", int'({emptyIrq, doneIrq}), 0);
    rstN = 1;
    repeat (2) @(negedge clk);
    txEnable = 1;
    @(negedge clk);
    // R11 enable takes the pin
    check(txDrive == 1 && txPin == 1, "R11 drive idle", int'({txDrive, txPin}), 3);

    // 8N1
    charSel = 3'd3; parityEn = 0; twoStop = 0;
    sendChar(9'h0A5);
    repeat (6) @(negedge clk);
    // R7 handoff on next tick while idle
    check(bufEmpty == 1, "R7 handoff", int'(bufEmpty), 1);
    waitDone();
    // R9 done after last stop
    check(txDone == 1, "R9 done set", int'(txDone), 1);

    // R10 gating
    emptyIrqEn = 1; doneIrqEn = 1; globalIrqEn = 0;
    @(negedge clk);
    check(emptyIrq == 0 && doneIrq == 0, "R10 global off", int'({emptyIrq, doneIrq}), 0);
    globalIrqEn = 1;
    @(negedge clk);
    check(emptyIrq == 1 && doneIrq == 1, "R10 all on", int'({emptyIrq, doneIrq}), 3);
    doneIrqEn = 0;
    @(negedge clk);
    check(doneIrq == 0 && emptyIrq == 1, "R10 done enable off", int'({emptyIrq, doneIrq}), 2);
    doneIrqEn = 1;

    // 5 bits, even parity, two stop; back-to-back with an ignored write
    charSel = 3'd0; parityEn = 1; parityOdd = 0; twoStop = 1;
    sendChar(9'h013);
    // R9 write clears done
    check(txDone == 0 && doneIrq == 0, "R9 done cleared", int'(txDone), 0);
    sendChar(9'h00E);
    @(negedge clk);
    check(bufEmpty == 0 && emptyIrq == 0, "R8 buffer full", int'(bufEmpty), 0);
    // R8 write while full must be ignored
    wrData = 8'h1F; wrBit8 = 0; wrEn = 1;
    @(negedge clk);
    wrEn = 0;
    waitDone();
    check(expQ.size() == 0, "R8 queue drained", expQ.size(), 0);

    // 7 bits, odd parity
    charSel = 3'd2; parityEn = 1; parityOdd = 1; twoStop = 0;
    sendChar(9'h05B);
    waitDone();

    // R6 nine bits, ninth from write
    charSel = 3'd4; parityEn = 1; parityOdd = 0;
    sendChar(9'h1C3);
    sendChar(9'h03C);
    waitDone();

    // R5 double speed
    dblSpeed = 1; charSel = 3'd3; parityEn = 1; parityOdd = 1; twoStop = 1;
    sendChar(9'h096);
    sendChar(9'h069);
    waitDone();
    dblSpeed = 0; parityEn = 0; twoStop = 0;

    // R11 deferred release
    sendChar(9'h0F0);
    sendChar(9'h00F);
    txEnable = 0;
    repeat (50) @(negedge clk);
    check(txDrive == 1, "R11 still driving", int'(txDrive), 1);
    waitDone();
    check(txDrive == 0 && txPin == 1, "R11 released", int'({txDrive, txPin}), 1);
    check(expQ.size() == 0, "R11 all frames sent", expQ.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule